// File: doc/BRIEF.md
# Bit Field Operation Unit

This execution unit works on a run of consecutive bits inside a 32-bit register word. An offset and a width select the run. Offset 0 names the most significant bit. A run that goes past bit 0 continues at bit 31. One opcode picks one of eight operations:
- pull the run out, zero-filled or sign-extended;
- locate the first one bit in the run;
- write a source value into the run;
- set, clear or invert the run;
- only examine the run.

Each operation also gives the N and Z flags of the run, taken as the run was before it changed.

A request is presented with a one-cycle strobe. The result word, the scan position and the flags are registered. They appear on the clock edge after the strobe, together with a one-cycle done pulse. The outputs then hold until the next strobe. There is no back-pressure, so a new request may be given on every cycle.

Top module: `bitfield_unit`

## Requirements
- R1: While reset (rstN low) is held, resultOut, scanOut, nFlag, zFlag and doneOut are all zero.
- R2: doneOut is high in exactly the cycle after a cycle with validIn high. resultOut, scanOut and the flags take their new values in that same cycle.
- R3: Field bit k (k = 0 first) sits at register bit 31 - ((offset + k) mod 32). The offset is offsetIn mod 32, and a widthIn of 0 means 32 bits. Fields therefore wrap from bit 0 to bit 31.
- R4: Opcode 0 (unsigned extract) returns the field right-justified with zero fill. The first field bit becomes the field's most significant bit.
- R5: Opcode 1 (signed extract) returns the field right-justified and sign-extended from its first bit.
- R6: Opcode 2 (find first one) returns on scanOut, and zero-extended on resultOut, the value (offset mod 32) + k. Here k is the index of the first field bit that is one.
- R7: When opcode 2 finds no one bit, it returns (offset mod 32) + width, where width is in 1..32.
- R8: Opcode 3 (insert) writes the low `width` bits of srcIn into the field. srcIn bit width-1 goes to field bit 0. Bits outside the field are unchanged.
- R9: Opcodes 4, 5 and 6 return destIn with the field set to all ones, cleared to all zeros, or inverted. Bits outside the field are unchanged.
- R10: Opcode 7 (test) returns destIn unchanged as resultOut.
- R11: For every opcode, nFlag is field bit 0 and zFlag is 1 exactly when the field is all zero. Both come from destIn before any change.
- R12: In a cycle after one with validIn low, resultOut, scanOut, nFlag and zFlag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Request strobe |
| opIn | input | 3 | Operation code (0..7) |
| destIn | input | 32 | Register word holding the field |
| srcIn | input | 32 | Value for insert |
| offsetIn | input | 8 | Field offset, used mod 32 |
| widthIn | input | 5 | Field width, 0 means 32 |
| resultOut | output | 32 | Modified word, extracted value or scan position |
| scanOut | output | 6 | First-one scan position |
| nFlag | output | 1 | First bit of the original field |
| zFlag | output | 1 | Original field is all zero |
| doneOut | output | 1 | Result valid pulse |

## Verification
The bench goes after fields that wrap past bit 0 and offsets of 32 or more. A design that gets these wrong touches the wrong bits or drops the upper part of a wrapped field. It also tries the 32-bit width given as code 0; a design that misreads it returns an empty field. The find-first-one cases with no set bit must give offset plus width, not zero or the last index. Signed extraction of a negative field must sign-extend, which shows whether the sign is taken from the field's top bit. Flags are compared after clear and set. A design that computes them from the modified word reports a wrong Z or N.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  typedef enum logic [2:0] {
    OP_EXTU = 3'd0,
    OP_EXTS = 3'd1,
    OP_FFO  = 3'd2,
    OP_INS  = 3'd3,
    OP_SET  = 3'd4,
    OP_CLR  = 3'd5,
    OP_CHG  = 3'd6,
    OP_TST  = 3'd7
  } bfOp_e;

  typedef struct packed {
    logic load;
  } bfStrobe_t;
endpackage

// File: rtl/bitfield_ctrl.sv
module bitfield_ctrl
  import bitfield_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      validIn,
  output bfStrobe_t strobe,
  output logic      doneOut
);
  assign strobe.load = validIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneOut <= 1'b0;
    else       doneOut <= validIn;
  end
endmodule

// File: rtl/bitfield_dp.sv
module bitfield_dp
  import bitfield_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 8,
  localparam int IW = $clog2(DW),
  localparam int SW = IW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  bfStrobe_t     strobe,
  input  logic [2:0]    opIn,
  input  logic [DW-1:0] destIn,
  input  logic [DW-1:0] srcIn,
  input  logic [OW-1:0] offsetIn,
  input  logic [IW-1:0] widthIn,
  output logic [DW-1:0] resultOut,
  output logic [SW-1:0] scanOut,
  output logic          nFlag,
  output logic          zFlag
);
  logic [IW-1:0] offLo;
  logic [SW-1:0] wEff;
  logic [DW-1:0] mask, fieldVal, insBits, lowMask, nextRes;
  logic [SW-1:0] scanIdx, scanPos;
  logic          scanHit, fieldTop;
  logic [IW-1:0] pos, regPos, fIdx;

  assign offLo = offsetIn[IW-1:0];
  assign wEff  = (widthIn == '0) ? SW'(DW) : {1'b0, widthIn};

  // Walk the field from its first bit; wrap comes from IW-bit arithmetic.
  always_comb begin
    mask     = '0;
    fieldVal = '0;
    insBits  = '0;
    scanHit  = 1'b0;
    scanIdx  = '0;
    pos      = '0;
    regPos   = '0;
    fIdx     = '0;
    for (int i = 0; i < DW; i++) begin
      pos    = offLo + IW'(i);
      regPos = IW'(DW - 1) - pos;
      fIdx   = IW'(wEff - SW'(i) - SW'(1));
      if (i < int'(wEff)) begin
        mask[regPos]    = 1'b1;
        fieldVal[fIdx]  = destIn[regPos];
        insBits[regPos] = srcIn[fIdx];
        if (!scanHit && destIn[regPos]) begin
          scanHit = 1'b1;
          scanIdx = SW'(i);
        end
      end
    end
  end

  assign fieldTop = destIn[IW'(DW - 1) - offLo];
  assign lowMask  = (wEff == SW'(DW)) ? '1 : ((DW'(1) << wEff) - DW'(1));
  assign scanPos  = SW'(offLo) + (scanHit ? scanIdx : wEff);

  always_comb begin
    case (bfOp_e'(opIn))
      OP_EXTU: nextRes = fieldVal;
      OP_EXTS: nextRes = fieldVal | (fieldTop ? ~lowMask : '0);
      OP_FFO:  nextRes = DW'(scanPos);
      OP_INS:  nextRes = (destIn & ~mask) | insBits;
      OP_SET:  nextRes = destIn | mask;
      OP_CLR:  nextRes = destIn & ~mask;
      OP_CHG:  nextRes = destIn ^ mask;
      default: nextRes = destIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      scanOut   <= '0;
      nFlag     <= 1'b0;
      zFlag     <= 1'b0;
    end else if (strobe.load) begin
      resultOut <= nextRes;
      scanOut   <= scanPos;
      nFlag     <= fieldTop;
      zFlag     <= (fieldVal == '0);
    end
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bitfield_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 8,
  localparam int IW = $clog2(DW),
  localparam int SW = IW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          validIn,
  input  logic [2:0]    opIn,
  input  logic [DW-1:0] destIn,
  input  logic [DW-1:0] srcIn,
  input  logic [OW-1:0] offsetIn,
  input  logic [IW-1:0] widthIn,
  output logic [DW-1:0] resultOut,
  output logic [SW-1:0] scanOut,
  output logic          nFlag,
  output logic          zFlag,
  output logic          doneOut
);
  bfStrobe_t strobe;

  bitfield_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .strobe(strobe), .doneOut(doneOut)
  );

  bitfield_dp #(.DW(DW), .OW(OW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIn(opIn), .destIn(destIn),
    .srcIn(srcIn), .offsetIn(offsetIn), .widthIn(widthIn), .resultOut(resultOut),
    .scanOut(scanOut), .nFlag(nFlag), .zFlag(zFlag)
  );
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int DW = 32,
  parameter int OW = 8,
  localparam int IW = $clog2(DW),
  localparam int SW = IW + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          validIn,
  input logic [2:0]    opIn,
  input logic [DW-1:0] destIn,
  input logic [OW-1:0] offsetIn,
  input logic [IW-1:0] widthIn,
  input logic [DW-1:0] resultOut,
  input logic [SW-1:0] scanOut,
  input logic          nFlag,
  input logic          zFlag,
  input logic          doneOut
);
  logic [SW-1:0] wNow;
  assign wNow = (widthIn == '0) ? SW'(DW) : {1'b0, widthIn};

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> doneOut);
  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !doneOut);
  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(resultOut) && $stable(scanOut) && $stable(nFlag) && $stable(zFlag)));
  // R10
  test_passes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opIn == 3'd7) |=> (resultOut == $past(destIn)));
  // R9
  set_only_adds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opIn == 3'd4) |=> ((resultOut & $past(destIn)) == $past(destIn)));
  // R9
  clr_only_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opIn == 3'd5) |=> ((resultOut & ~$past(destIn)) == '0));
  // R4
  extu_fits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opIn == 3'd0 && widthIn != '0) |=> ((resultOut >> $past(widthIn)) == '0));
  // R7
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> (scanOut <= SW'($past(offsetIn[IW-1:0])) + $past(wNow)));
endmodule

bind bitfield_unit bitfield_unit_chk #(.DW(DW), .OW(OW)) i_chk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn), .destIn(destIn),
  .offsetIn(offsetIn), .widthIn(widthIn), .resultOut(resultOut), .scanOut(scanOut),
  .nFlag(nFlag), .zFlag(zFlag), .doneOut(doneOut)
);

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [2:0]  opIn = '0;
  logic [31:0] destIn = '0, srcIn = '0;
  logic [7:0]  offsetIn = '0;
  logic [4:0]  widthIn = '0;
  logic [31:0] resultOut;
  logic [5:0]  scanOut;
  logic        nFlag, zFlag, doneOut;

  int checks = 0, fails = 0, cycles = 0;

  logic [31:0] expRes = '0;
  logic [5:0]  expScan = '0;
  logic        expN = 0, expZ = 0, expDone = 0;
  string       expTag = "R1";

  always #2 clk = ~clk;

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn), .destIn(destIn),
    .srcIn(srcIn), .offsetIn(offsetIn), .widthIn(widthIn), .resultOut(resultOut),
    .scanOut(scanOut), .nFlag(nFlag), .zFlag(zFlag), .doneOut(doneOut)
  );

  function automatic logic [31:0] rotl(logic [31:0] x, int n);
    logic [63:0] d = {x, x} << n;
    return d[63:32];
  endfunction

  function automatic logic [31:0] rotr(logic [31:0] x, int n);
    logic [63:0] d = {x, x} >> n;
    return d[31:0];
  endfunction

  // Behavioural reference: rotate the field up to bit 31 and work there.
  task automatic refModel(input int op, input logic [31:0] d, input logic [31:0] s,
                          input int offRaw, input int wRaw,
                          output logic [31:0] res, output logic [5:0] sc,
                          output logic n, output logic z, output string tag);
    int off = offRaw % 32;
    int w = (wRaw == 0) ? 32 : wRaw;
    logic [31:0] r = rotl(d, off);
    logic [31:0] fv = r >> (32 - w);
    logic [31:0] mask = rotr(~(32'hFFFF_FFFF >> w), off);
    int hit = -1;
    for (int i = 0; i < w; i++) if (hit < 0 && r[31 - i]) hit = i;
    sc = 6'(off + ((hit < 0) ? w : hit));
    n = r[31];
    z = (fv == 0);
    case (op)
      0: begin res = fv; tag = "R4"; end
      1: begin res = (n && w < 32) ? (fv | ~((32'd1 << w) - 1)) : fv; tag = "R5"; end
      2: begin res = {26'd0, sc}; tag = (hit < 0) ? "R7" : "R6"; end
      3: begin res = (d & ~mask) | rotr(s << (32 - w), off); tag = "R8"; end
      4: begin res = d | mask; tag = "R9"; end
      5: begin res = d & ~mask; tag = "R9"; end
      6: begin res = d ^ mask; tag = "R9"; end
      default: begin res = d; tag = "R10"; end
    endcase
    if (op != 2 && (offRaw >= 32 || wRaw == 0 || off + w > 32)) tag = "R3";
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      expRes <= '0; expScan <= '0; expN <= 0; expZ <= 0; expDone <= 0; expTag <= "R1";
    end else begin
      expDone <= validIn;
      if (validIn) begin
        logic [31:0] r; logic [5:0] sc; logic n, z; string t;
        refModel(int'(opIn), destIn, srcIn, int'(offsetIn), int'(widthIn), r, sc, n, z, t);
        expRes <= r; expScan <= sc; expN <= n; expZ <= z; expTag <= t;
      end else begin
        expTag <= "R12";
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    chk(expTag, "result", resultOut, expRes);
    chk(expTag, "scan", 32'(scanOut), 32'(expScan));
    chk((expTag == "R12" || expTag == "R1") ? expTag : "R11", "nFlag", 32'(nFlag), 32'(expN));
    chk((expTag == "R12" || expTag == "R1") ? expTag : "R11", "zFlag", 32'(zFlag), 32'(expZ));
    chk((expTag == "R1") ? "R1" : "R2", "done", 32'(doneOut), 32'(expDone));
  end

  task automatic req(input int op, input logic [31:0] d, input logic [31:0] s, input int off, input int w);
    @(negedge clk);
    validIn = 1; opIn = 3'(op); destIn = d; srcIn = s; offsetIn = 8'(off); widthIn = 5'(w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 0; destIn = $urandom; opIn = 3'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    req(0, 32'hA5C3_0000, 0, 0, 8);      // R4 top byte
    req(1, 32'h0F00_0000, 0, 4, 4);      // R5 negative field
    req(1, 32'h0700_0000, 0, 4, 4);      // R5 positive field
    req(0, 32'h1234_5678, 0, 5, 0);      // R3 width code 0
    req(0, 32'h8000_0001, 0, 28, 8);     // R3 wrap past bit 0
    req(0, 32'h1234_5678, 0, 40, 4);     // R3 offset mod 32
    req(2, 32'h0010_0000, 0, 3, 20);     // R6
    req(2, 32'h0000_0000, 0, 30, 0);     // R7 no ones, full width
    req(2, 32'hF000_000F, 0, 10, 6);     // R7
    req(3, 32'hFFFF_FFFF, 32'h0000_00A5, 28, 8); // R8 wrap insert
    req(4, 32'h0, 0, 30, 4);             // R9 set wrap
    req(5, 32'hFFFF_FFFF, 0, 8, 8);      // R9 clear, R11 flags from original
    req(6, 32'h0F0F_0F0F, 0, 0, 0);      // R9 invert all
    req(7, 32'hDEAD_BEEF, 0, 12, 9);     // R10
    idle(3);                             // R12
    for (int k = 0; k < 400; k++) begin
      req(int'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom,
          $urandom, int'($urandom_range(0, 255)), int'($urandom_range(0, 31)));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 2)));
    end
    idle(2);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=%0d expected<=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule